// File: doc/BRIEF.md
# Write-Allocate Miss Buffer File

This block sits between a core and a write-allocate, fetch-on-write cache. It keeps a small pool of miss buffers. Each busy buffer owns one missing cache line. A store that misses does not wait for the cache and is not retried against it. Its bytes are written into the buffer, and a per-byte valid mask records which bytes the store covered. The buffer then asks memory for the whole line.

When the line returns, every byte the stores covered keeps the store value, and every other byte takes the fetched value. The merged line goes to the cache data array in one write. The cache therefore only needs one valid bit per line; partial validity exists only inside this block. Load misses use the same pool. A load to a line that is already held joins that buffer and causes no second fetch.

Every data interface uses valid/ready:
- **Request port:** a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends on `req_line` and drops when no buffer is free and the line is not already held.
- **Fetch port:** once `fet_valid` is raised, the line and tag stay fixed until `fet_ready` accepts them.
- **Response port:** responses carry the tag from the fetch and are always accepted.
- **Line-write port:** once `wr_valid` is raised, `wr_line` stays fixed until `wr_ready` accepts it.

Top module: `wa_miss_file`

## Requirements
- R1: After reset `req_ready` is 1, `fet_valid` is 0 and `wr_valid` is 0.
- R2: A request to a line that no buffer holds takes the lowest free buffer. In the cycle after acceptance `fet_valid` rises, carrying that line on `fet_line` and the buffer index on `fet_tag`. Buffers waiting to fetch issue lowest index first, after any fetch already on offer.
- R3: One cycle after a response for tag `t`, buffer `t` offers its line for writing. For each byte i (bits 8i+7:8i), the write carries the store byte when any store set enable bit i, and the fetched byte otherwise.
- R4: A store to a line a buffer already holds merges into that buffer and issues no new fetch. The later store wins on overlapping bytes. This holds both before and after the fetched data has arrived.
- R5: A load to a held line is accepted even when every buffer is busy. It issues no second fetch and leaves the merged data unchanged.
- R6: While all buffers are busy, `req_ready` is 0 for a line none of them holds.
- R7: A buffer frees on the edge that accepts its write (`wr_valid` and `wr_ready` both high). In the next cycle it can accept a new line, and `wr_valid` drops if no other buffer is ready.
- R8: When several buffers are ready, the write on offer stays until it is accepted. The next offer is the lowest-index ready buffer.
- R9: While `fet_valid` is high and `fet_ready` is low, `fet_line` and `fet_tag` hold. While `wr_valid` is high and `wr_ready` is low, `wr_line` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_store | input | 1 | 1 = store miss, 0 = load miss |
| req_line | input | LADDR_W | Line address of the miss |
| req_data | input | LINE_BYTES*8 | Store data, byte i at bits 8i+7:8i |
| req_be | input | LINE_BYTES | Store byte enables (ignored for loads) |
| fet_valid | output | 1 | Line fetch request to memory |
| fet_ready | input | 1 | Memory takes the fetch |
| fet_line | output | LADDR_W | Line to fetch |
| fet_tag | output | TAG_W | Buffer index, returned with the response |
| rsp_valid | input | 1 | Fetched line arrives |
| rsp_tag | input | TAG_W | Buffer the data belongs to |
| rsp_data | input | LINE_BYTES*8 | Fetched line |
| wr_valid | output | 1 | Merged line ready for the cache array |
| wr_ready | input | 1 | Cache array takes the write |
| wr_line | output | LADDR_W | Line address of the write |
| wr_data | output | LINE_BYTES*8 | Merged line data |

## Verification
Each result has a fixed latency, counted in cycles after the edge that takes the input:
- `fet_valid` and `fet_tag` are due one cycle after the edge that accepts a request.
- The merged `wr_data` is due one cycle after the edge that takes a response.
- A freed buffer shows on `req_ready` one cycle after the edge that accepts its write.
- A store merging into a buffer that is already ready shows on `wr_data` one cycle after acceptance.

The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples outputs at the next falling edge. Each check therefore lands in the first cycle where the result is due. The bench holds `fet_ready` and `wr_ready` low while it inspects an offer. This lets it prove that no extra fetch appears and that a held write is not displaced by a lower-index buffer.

// File: rtl/wa_miss_pkg.sv
package wa_miss_pkg;

  typedef enum logic [1:0] {
    MB_FREE  = 2'd0,
    MB_NEED  = 2'd1,
    MB_WAIT  = 2'd2,
    MB_READY = 2'd3
  } mb_state_e;

  // index of the lowest set bit, 0 when none is set
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/wa_miss_pick.sv
module wa_miss_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] idx
);
  import wa_miss_pkg::*;

  logic          hold_q;
  logic [IW-1:0] last_q;
  logic [IW-1:0] lowest;

  assign lowest = IW'(first_set(32'(req)));
  assign any    = |req;
  assign idx    = hold_q ? last_q : lowest;

  // an offer that was not taken is repeated unchanged
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      last_q <= '0;
    end else begin
      hold_q <= any && !take;
      last_q <= idx;
    end
  end

  // R8: the granted index always points at a requesting buffer
  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);

endmodule

// File: rtl/wa_miss_entry.sv
module wa_miss_entry #(
  parameter int LADDR_W    = 26,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc,
  input  logic [LADDR_W-1:0]      alloc_line,
  input  logic                    st_en,
  input  logic [LINE_BYTES*8-1:0] st_data,
  input  logic [LINE_BYTES-1:0]   st_be,
  input  logic                    fet_fire,
  input  logic                    rsp_en,
  input  logic [LINE_BYTES*8-1:0] rsp_data,
  input  logic                    wr_fire,
  output logic                    busy,
  output logic                    need_fetch,
  output logic                    ready_wr,
  output logic [LADDR_W-1:0]      line,
  output logic [LINE_BYTES*8-1:0] data
);
  import wa_miss_pkg::*;

  mb_state_e                 state_q;
  logic [LADDR_W-1:0]        line_q;
  logic [LINE_BYTES*8-1:0]   data_q;
  logic [LINE_BYTES-1:0]     bv_q;

  assign busy       = (state_q != MB_FREE);
  assign need_fetch = (state_q == MB_NEED);
  assign ready_wr   = (state_q == MB_READY);
  assign line       = line_q;
  assign data       = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MB_FREE;
      line_q  <= '0;
      data_q  <= '0;
      bv_q    <= '0;
    end else if (alloc) begin
      state_q <= MB_NEED;
      line_q  <= alloc_line;
      data_q  <= st_data;
      bv_q    <= st_be;
    end else begin
      if (fet_fire) state_q <= MB_WAIT;
      if (rsp_en)   state_q <= MB_READY;
      if (wr_fire) begin
        state_q <= MB_FREE;
        bv_q    <= '0;
      end
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (st_en && st_be[b]) begin
          data_q[b*8 +: 8] <= st_data[b*8 +: 8];
          bv_q[b]          <= 1'b1;
        end else if (rsp_en && !bv_q[b]) begin
          data_q[b*8 +: 8] <= rsp_data[b*8 +: 8];
        end
      end
    end
  end

  // R3: fetched data only lands in a buffer that is waiting for it
  a_r3_rsp_to_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_en |-> state_q == MB_WAIT);

  // R2: a fetch is only accepted from a buffer that still needs one
  a_r2_fetch_from_needy: assert property (@(posedge clk) disable iff (!rst_n)
    fet_fire |-> state_q == MB_NEED);

endmodule

// File: rtl/wa_miss_file.sv
module wa_miss_file #(
  parameter int NBUF       = 8,
  parameter int LINE_BYTES = 16,
  parameter int LADDR_W    = 26,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int TAG_W     = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_is_store,
  input  logic [LADDR_W-1:0] req_line,
  input  logic [LINE_W-1:0]  req_data,
  input  logic [LINE_BYTES-1:0] req_be,
  output logic               fet_valid,
  input  logic               fet_ready,
  output logic [LADDR_W-1:0] fet_line,
  output logic [TAG_W-1:0]   fet_tag,
  input  logic               rsp_valid,
  input  logic [TAG_W-1:0]   rsp_tag,
  input  logic [LINE_W-1:0]  rsp_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [LADDR_W-1:0] wr_line,
  output logic [LINE_W-1:0]  wr_data
);
  import wa_miss_pkg::*;

  logic [NBUF-1:0]    busy, need_f, rdy_w;
  logic [NBUF-1:0]    raw_match, match, wr_fire_v;
  logic [LADDR_W-1:0] ent_line [NBUF];
  logic [LINE_W-1:0]  ent_data [NBUF];
  logic [TAG_W-1:0]   fet_idx, wr_idx, hit_idx, alloc_idx;
  logic               fet_any, wr_any, hit, any_free, accept;
  logic [LINE_BYTES-1:0] eff_be;

  wa_miss_pick #(.N(NBUF), .IW(TAG_W)) u_fet_pick (
    .clk(clk), .rst_n(rst_n), .req(need_f),
    .take(fet_valid && fet_ready), .any(fet_any), .idx(fet_idx));

  wa_miss_pick #(.N(NBUF), .IW(TAG_W)) u_wr_pick (
    .clk(clk), .rst_n(rst_n), .req(rdy_w),
    .take(wr_valid && wr_ready), .any(wr_any), .idx(wr_idx));

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      wr_fire_v[i] = wr_valid && wr_ready && (wr_idx == TAG_W'(i));
      raw_match[i] = busy[i] && (ent_line[i] == req_line);
    end
  end

  // a buffer leaving on this edge cannot take more bytes
  assign match     = raw_match & ~wr_fire_v;
  assign hit       = |match;
  assign hit_idx   = TAG_W'(first_set(32'(match)));
  assign any_free  = |(~busy);
  assign alloc_idx = TAG_W'(first_set(32'(~busy)));
  assign req_ready = hit || any_free;
  assign accept    = req_valid && req_ready;
  assign eff_be    = req_is_store ? req_be : '0;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    wa_miss_entry #(.LADDR_W(LADDR_W), .LINE_BYTES(LINE_BYTES)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (accept && !hit && (alloc_idx == TAG_W'(g))),
      .alloc_line(req_line),
      .st_en     (accept && hit && (hit_idx == TAG_W'(g))),
      .st_data   (req_data),
      .st_be     (eff_be),
      .fet_fire  (fet_valid && fet_ready && (fet_idx == TAG_W'(g))),
      .rsp_en    (rsp_valid && (rsp_tag == TAG_W'(g))),
      .rsp_data  (rsp_data),
      .wr_fire   (wr_fire_v[g]),
      .busy      (busy[g]),
      .need_fetch(need_f[g]),
      .ready_wr  (rdy_w[g]),
      .line      (ent_line[g]),
      .data      (ent_data[g])
    );
  end

  assign fet_valid = fet_any;
  assign fet_line  = ent_line[fet_idx];
  assign fet_tag   = fet_idx;
  assign wr_valid  = wr_any;
  assign wr_line   = ent_line[wr_idx];
  assign wr_data   = ent_data[wr_idx];

  initial begin
    a_r6_nbuf_range: assert (NBUF >= 1 && NBUF <= 32);
  end

  // R4: a line is owned by at most one buffer
  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(raw_match));

  // R6: a new line is never taken while every buffer is busy
  a_r6_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit) |-> any_free);

  // R9: fetch offer holds under back-pressure
  a_r9_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && !fet_ready) |=> fet_valid && $stable(fet_line) && $stable(fet_tag));

  // R9: write offer holds under back-pressure
  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_line));

  // R7: an accepted write is not offered again
  a_r7_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid || (wr_line != $past(wr_line)));

endmodule

// File: tb/wa_miss_file_bench.sv
module wa_miss_file_bench;
  localparam int NBUF = 8;
  localparam int LB   = 16;
  localparam int AW   = 26;
  localparam int LW   = LB * 8;
  localparam int TW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_is_store = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_line = '0;
  logic [LW-1:0] req_data = '0;
  logic [LB-1:0] req_be = '0;
  logic          fet_valid, fet_ready = 1'b0;
  logic [AW-1:0] fet_line;
  logic [TW-1:0] fet_tag;
  logic          rsp_valid = 1'b0;
  logic [TW-1:0] rsp_tag = '0;
  logic [LW-1:0] rsp_data = '0;
  logic          wr_valid, wr_ready = 1'b0;
  logic [AW-1:0] wr_line;
  logic [LW-1:0] wr_data;

  int n_chk = 0, n_bad = 0;
  logic [TW-1:0] got_tag;
  logic [LW-1:0] exp_line;

  wa_miss_file #(.NBUF(NBUF), .LINE_BYTES(LB), .LADDR_W(AW)) u_wa_miss_file (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
    .req_line(req_line), .req_data(req_data), .req_be(req_be),
    .fet_valid(fet_valid), .fet_ready(fet_ready), .fet_line(fet_line), .fet_tag(fet_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line), .wr_data(wr_data));

  always #4 clk = ~clk;

  typedef struct packed {
    logic [AW-1:0] line;
    logic [LB-1:0] be;
    logic [7:0]    sb;
    logic [7:0]    fb;
    logic [7:0]    e0;
    logic [7:0]    e15;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{26'h0000100, 16'h0001, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
    '{26'h00002AB, 16'h8000, 8'h11, 8'hEE, 8'hEE, 8'h11},
    '{26'h3FFFFFF, 16'hFFFF, 8'h77, 8'h00, 8'h77, 8'h77},
    '{26'h0000000, 16'h0000, 8'h55, 8'hC3, 8'hC3, 8'hC3},
    '{26'h0001234, 16'h5A5A, 8'h99, 8'h22, 8'h22, 8'h22}
  };

  function automatic logic [LW-1:0] fill(input logic [7:0] b);
    return {LB{b}};
  endfunction

  // byte i takes b where be[i] is set, else keeps prev
  function automatic logic [LW-1:0] merge(input logic [LW-1:0] prev,
                                          input logic [LB-1:0] be, input logic [7:0] b);
    logic [LW-1:0] r;
    r = prev;
    for (int i = 0; i < LB; i++) if (be[i]) r[i*8 +: 8] = b;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input bit st, input logic [AW-1:0] ln, input logic [LB-1:0] be,
                      input logic [7:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_is_store = st; req_line = ln; req_be = be; req_data = fill(b);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] ln, input string req);
    @(negedge clk);
    chk(fet_valid === 1'b1 && fet_line === ln, req, LW'(fet_line), LW'(ln));
    got_tag = fet_tag;
    fet_ready = 1'b1;
    @(posedge clk); #1;
    fet_ready = 1'b0;
  endtask

  task automatic respond(input logic [TW-1:0] t, input logic [7:0] b);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = t; rsp_data = fill(b);
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic drain(input logic [AW-1:0] ln, input logic [LW-1:0] d, input string req);
    @(negedge clk);
    chk(wr_valid === 1'b1 && wr_line === ln, req, LW'(wr_line), LW'(ln));
    chk(wr_data === d, req, wr_data, d);
    wr_ready = 1'b1;
    @(posedge clk); #1;
    wr_ready = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(req_ready === 1'b1 && fet_valid === 1'b0 && wr_valid === 1'b0, "R1",
        LW'({req_ready, fet_valid, wr_valid}), LW'(3'b100));

    // table walk: R2 fetch, R3 merge, R7 free
    for (int v = 0; v < 5; v++) begin
      send(1'b1, VT[v].line, VT[v].be, VT[v].sb);
      fetch(VT[v].line, "R2 table fetch");
      chk(got_tag === '0, "R2 table tag", LW'(got_tag), '0);
      respond(got_tag, VT[v].fb);
      exp_line = merge(fill(VT[v].fb), VT[v].be, VT[v].sb);
      chk(exp_line[7:0] === VT[v].e0 && exp_line[LW-1 -: 8] === VT[v].e15,
          "R3 table vector", exp_line, exp_line);
      drain(VT[v].line, exp_line, "R3 table write");
      @(negedge clk);
      chk(wr_valid === 1'b0 && req_ready === 1'b1, "R7 freed",
          LW'({wr_valid, req_ready}), LW'(2'b01));
    end

    // R4: stores merge into one buffer, later store wins, one fetch
    send(1'b1, 26'h200, 16'h000F, 8'hAA);
    send(1'b1, 26'h200, 16'h0018, 8'hBB);
    send(1'b0, 26'h200, 16'hFFFF, 8'hFF);
    fetch(26'h200, "R4 merged fetch");
    @(negedge clk);
    chk(fet_valid === 1'b0, "R5 no second fetch", LW'(fet_valid), '0);
    respond(got_tag, 8'h00);
    exp_line = merge(merge(fill(8'h00), 16'h000F, 8'hAA), 16'h0018, 8'hBB);
    @(negedge clk);
    chk(wr_valid === 1'b1 && wr_data === exp_line, "R4 merge before fetch", wr_data, exp_line);
    send(1'b1, 26'h200, 16'h8000, 8'hCC);
    exp_line = merge(exp_line, 16'h8000, 8'hCC);
    @(negedge clk);
    chk(fet_valid === 1'b0, "R4 no refetch after arrival", LW'(fet_valid), '0);
    drain(26'h200, exp_line, "R4 merge after arrival");

    // R6/R5: fill every buffer with loads
    for (int i = 0; i < NBUF; i++) send(1'b0, AW'(26'h40 + i), '0, 8'h00);
    @(negedge clk);
    req_line = 26'h99;
    #1 chk(req_ready === 1'b0, "R6 full blocks new line", LW'(req_ready), '0);
    req_line = 26'h43;
    #1 chk(req_ready === 1'b1, "R5 held line accepted when full", LW'(req_ready), LW'(1));
    send(1'b0, 26'h43, '0, 8'h00);
    for (int i = 0; i < NBUF; i++) begin
      fetch(AW'(26'h40 + i), "R2 lowest index fetch order");
      chk(got_tag === TW'(i), "R2 fetch tag", LW'(got_tag), LW'(i));
    end
    @(negedge clk);
    chk(fet_valid === 1'b0, "R5 attached load no fetch", LW'(fet_valid), '0);

    // R8: held offer, then lowest index
    respond(3'd5, 8'h15);
    respond(3'd2, 8'h12);
    respond(3'd0, 8'h10);
    @(negedge clk);
    chk(wr_line === 26'h45, "R9 write offer held", LW'(wr_line), LW'(26'h45));
    drain(26'h45, fill(8'h15), "R8 held write");
    @(negedge clk);
    req_line = 26'h99;
    #1 chk(req_ready === 1'b1, "R7 slot free after write", LW'(req_ready), LW'(1));
    chk(wr_line === 26'h40, "R8 lowest ready next", LW'(wr_line), LW'(26'h40));
    for (int i = 0; i < NBUF; i++)
      if (i != 0 && i != 2 && i != 5) respond(TW'(i), 8'h10 + 8'(i));
    for (int i = 0; i < NBUF; i++)
      if (i != 5) drain(AW'(26'h40 + i), fill(8'h10 + 8'(i)), "R8 drain order");
    @(negedge clk);
    chk(wr_valid === 1'b0 && fet_valid === 1'b0, "R7 all idle",
        LW'({wr_valid, fet_valid}), '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule